// File: doc/BRIEF.md
# Chip-select bus cycle strobe generator

This block runs one read or write access on an external asynchronous bus region, for example a 16-bit IDE-style storage device in programmed I/O mode. When a request is accepted, the address is driven for a setup window. Chip-enable then asserts, and after a second delay either the read strobe or the write strobe pulses low. A hold window keeps chip-enable asserted after the strobe ends. A final pause with chip-enable released brings the cycle up to the minimum cycle time. A one-cycle done pulse then marks the end of the access.

Each phase length comes from a field in minus-one form: a field value F gives F+1 base units. Every base unit is scaled by a multiplier chosen by a 2-bit code. When dynamic wait is enabled, the device ready input, after a two-stage synchronizer, can hold the strobe low beyond its programmed width. A wait limit stops a device that never becomes ready and sets a sticky error flag. Read data is captured on the clock edge that ends the read strobe.

Top module: `csbus_strobe_gen`

## Requirements
- R1: After reset, `bus_ce_n`, `bus_oe_n` and `bus_we_n` are high, `req_ready` is 1, and `done` and `wait_err` are 0.
- R2: An accepted request first holds `req_ready` low with `bus_ce_n` high for (`cfg_adr`+1)×M cycles while `bus_addr` shows the request address. `bus_addr` stays constant until the access ends.
- R3: `bus_ce_n` then goes low, with both strobes high, for (`cfg_ce`+1)×M cycles.
- R4: Without stretch, the strobe stays low for (field+1)×M cycles. A read pulses `bus_oe_n` using `cfg_oe`, and a write pulses `bus_we_n` using `cfg_we`. The other strobe stays high throughout.
- R5: After the strobe, `bus_ce_n` stays low with both strobes high for (`cfg_wr_hld`+1)×M cycles on a write, or (`cfg_rd_hld`+1)×M cycles on a read.
- R6: A pause with `bus_ce_n` high lasts (`cfg_pause`+1)×M cycles. In the next cycle `done` is 1 for exactly one cycle and `req_ready` is 1.
- R7: The multiplier M is decoded from `cfg_mult` as follows: 1 gives ×1, 2 gives ×2, 0 gives ×4 and 3 gives ×8.
- R8: With `cfg_wait_en`=1, a low `dev_iordy` holds the strobe low past its programmed width. If `dev_iordy` rises during the k-th strobe-low cycle, the strobe lasts max(N, k+2) cycles, where N is the programmed width.
- R9: With `cfg_wait_en`=0, `dev_iordy` has no effect on the strobe width.
- R10: If `dev_iordy` never rises, the stretch is cut after 256 cycles at the end count, giving N+255 strobe cycles. `wait_err` is then set, and it clears when the next request is accepted.
- R11: On a read, `rdata` takes the value that `bus_rdata` had in the last strobe-low cycle. A write leaves `rdata` unchanged.
- R12: On a write, `bus_data_oe` is 1 exactly while `bus_ce_n` is low, and `bus_wdata` equals the request data. On a read, `bus_data_oe` stays 0.
- R13: A request is taken only while `req_ready` is 1. A `req_valid` pulse during an access is dropped, and no second access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request, taken when `req_ready` is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Block idle, a request will be accepted |
| cfg_mult | input | 2 | Time multiplier code |
| cfg_adr | input | FIELD_W | Address setup count, minus one |
| cfg_ce | input | FIELD_W | Chip-enable to strobe count, minus one |
| cfg_oe | input | FIELD_W | Read strobe width, minus one |
| cfg_we | input | FIELD_W | Write strobe width, minus one |
| cfg_rd_hld | input | FIELD_W | Hold after a read, minus one |
| cfg_wr_hld | input | FIELD_W | Hold after a write, minus one |
| cfg_pause | input | FIELD_W | Trailing pause, minus one |
| cfg_wait_en | input | 1 | Enable dynamic wait on `dev_iordy` |
| dev_iordy | input | 1 | Device ready, asynchronous |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_data_oe | output | 1 | Drive enable for the data bus |
| bus_rdata | input | DATA_W | Bus read data |
| bus_ce_n | output | 1 | Chip-enable, active low |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| done | output | 1 | One-cycle end-of-access pulse |
| rdata | output | DATA_W | Captured read data |
| wait_err | output | 1 | Sticky wait-limit error |

## Verification
The assertions assume that the `cfg_*` fields and `req_write` stay steady from acceptance until `done`, and that `dev_iordy` changes only between clock edges. The bench sets every timing field and the direction before raising `req_valid`, and it holds them until the done pulse. It changes `dev_iordy` only at falling clock edges. Random field values are kept small so that every access finishes quickly. The wait limit is only reached in directed accesses, never in random ones, so each strobe-low run stays below the bound the checker counts.

// File: rtl/csb_pkg.sv
package csb_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_ADDR   = 3'd1,
      PH_SETUP  = 3'd2,
      PH_STROBE = 3'd3,
      PH_HOLD   = 3'd4,
      PH_PAUSE  = 3'd5
   } phase_e;

   // multiplier code to left-shift amount: 1 -> x1, 2 -> x2, 0 -> x4, 3 -> x8
   function automatic logic [1:0] mult_shift(input logic [1:0] code);
      case (code)
         2'd1:    return 2'd0;
         2'd2:    return 2'd1;
         2'd0:    return 2'd2;
         default: return 2'd3;
      endcase
   endfunction

endpackage

// File: rtl/csb_iordy_sync.sv
module csb_iordy_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_sync = d_async;
      end else begin : g_chain
         logic [STAGES-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= {STAGES{RESET_VAL}};
            else if (STAGES == 1) stage_q <= d_async;
            else stage_q <= {stage_q[STAGES-2:0], d_async};
         end
         assign q_sync = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/csb_phase_timer.sv
module csb_phase_timer #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/csb_wait_guard.sv
module csb_wait_guard #(
   parameter int LIMIT = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic limit_hit
);

   localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;

   logic [W-1:0] wcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     wcnt_q <= '0;
      else if (clear) wcnt_q <= '0;
      else if (step)  wcnt_q <= wcnt_q + W'(1);
   end

   assign limit_hit = (wcnt_q == W'(LIMIT - 1));

endmodule

// File: rtl/csbus_strobe_gen.sv
module csbus_strobe_gen
   import csb_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int FIELD_W     = 6,
   parameter int WAIT_LIMIT  = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_wdata,
   output logic               req_ready,
   input  logic [1:0]         cfg_mult,
   input  logic [FIELD_W-1:0] cfg_adr,
   input  logic [FIELD_W-1:0] cfg_ce,
   input  logic [FIELD_W-1:0] cfg_oe,
   input  logic [FIELD_W-1:0] cfg_we,
   input  logic [FIELD_W-1:0] cfg_rd_hld,
   input  logic [FIELD_W-1:0] cfg_wr_hld,
   input  logic [FIELD_W-1:0] cfg_pause,
   input  logic               cfg_wait_en,
   input  logic               dev_iordy,
   output logic [ADDR_W-1:0]  bus_addr,
   output logic [DATA_W-1:0]  bus_wdata,
   output logic               bus_data_oe,
   input  logic [DATA_W-1:0]  bus_rdata,
   output logic               bus_ce_n,
   output logic               bus_oe_n,
   output logic               bus_we_n,
   output logic               done,
   output logic [DATA_W-1:0]  rdata,
   output logic               wait_err
);

   // largest phase: 2^FIELD_W units times 8 needs FIELD_W+3 bits for count-1
   localparam int CNT_W = FIELD_W + 3;

   generate
      if (FIELD_W < 1 || FIELD_W > 16) begin : g_bad_field
         $error("csbus_strobe_gen: FIELD_W out of range");
      end
      if (WAIT_LIMIT < 2) begin : g_bad_limit
         $error("csbus_strobe_gen: WAIT_LIMIT must be at least 2");
      end
      if (ADDR_W < 1 || DATA_W < 8) begin : g_bad_bus
         $error("csbus_strobe_gen: bus widths too small");
      end
   endgenerate

   phase_e state_q, state_d;

   logic              iordy_s;
   logic              tmr_load, tmr_zero;
   logic [CNT_W-1:0]  tmr_val;
   logic              wait_step, wait_hit, stretch_cut;
   logic              write_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [FIELD_W-1:0] fsel;
   logic              ce_window;

   csb_iordy_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (dev_iordy),
      .q_sync  (iordy_s)
   );

   csb_phase_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_zero)
   );

   csb_wait_guard #(
      .LIMIT (WAIT_LIMIT)
   ) u_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (state_q != PH_STROBE),
      .step      (wait_step),
      .limit_hit (wait_hit)
   );

   // phase sequencing
   always_comb begin
      state_d     = state_q;
      wait_step   = 1'b0;
      stretch_cut = 1'b0;
      case (state_q)
         PH_IDLE:  if (req_valid) state_d = PH_ADDR;
         PH_ADDR:  if (tmr_zero)  state_d = PH_SETUP;
         PH_SETUP: if (tmr_zero)  state_d = PH_STROBE;
         PH_STROBE: begin
            if (tmr_zero) begin
               if (cfg_wait_en && !iordy_s) begin
                  if (wait_hit) begin
                     stretch_cut = 1'b1;
                     state_d     = PH_HOLD;
                  end else begin
                     wait_step = 1'b1;
                  end
               end else begin
                  state_d = PH_HOLD;
               end
            end
         end
         PH_HOLD:  if (tmr_zero) state_d = PH_PAUSE;
         PH_PAUSE: if (tmr_zero) state_d = PH_IDLE;
         default:  state_d = PH_IDLE;
      endcase
   end

   // length of the phase being entered, in cycles minus one
   always_comb begin
      case (state_d)
         PH_ADDR:   fsel = cfg_adr;
         PH_SETUP:  fsel = cfg_ce;
         PH_STROBE: fsel = write_q ? cfg_we : cfg_oe;
         PH_HOLD:   fsel = write_q ? cfg_wr_hld : cfg_rd_hld;
         PH_PAUSE:  fsel = cfg_pause;
         default:   fsel = '0;
      endcase
      tmr_val  = ((CNT_W'(fsel) + CNT_W'(1)) << mult_shift(cfg_mult)) - CNT_W'(1);
      tmr_load = (state_d != state_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= PH_IDLE;
         addr_q   <= '0;
         wdata_q  <= '0;
         write_q  <= 1'b0;
         rdata    <= '0;
         wait_err <= 1'b0;
         done     <= 1'b0;
      end else begin
         state_q <= state_d;
         done    <= (state_q == PH_PAUSE) && (state_d == PH_IDLE);
         if (state_q == PH_IDLE && req_valid) begin
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
            write_q  <= req_write;
            wait_err <= 1'b0;
         end
         if (stretch_cut) wait_err <= 1'b1;
         if (state_q == PH_STROBE && state_d == PH_HOLD && !write_q)
            rdata <= bus_rdata;
      end
   end

   assign ce_window   = (state_q == PH_SETUP) || (state_q == PH_STROBE) || (state_q == PH_HOLD);
   assign req_ready   = (state_q == PH_IDLE);
   assign bus_ce_n    = !ce_window;
   assign bus_oe_n    = !((state_q == PH_STROBE) && !write_q);
   assign bus_we_n    = !((state_q == PH_STROBE) && write_q);
   assign bus_data_oe = ce_window && write_q;
   assign bus_addr    = addr_q;
   assign bus_wdata   = wdata_q;

endmodule

// File: rtl/csbus_strobe_gen_chk.sv
module csbus_strobe_gen_chk #(
   parameter int ADDR_W     = 16,
   parameter int FIELD_W    = 6,
   parameter int WAIT_LIMIT = 256
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              done,
   input logic              bus_ce_n,
   input logic              bus_oe_n,
   input logic              bus_we_n,
   input logic              bus_data_oe,
   input logic              wait_err,
   input logic [ADDR_W-1:0] bus_addr
);

   localparam int STROBE_MAX = (8 << FIELD_W) + WAIT_LIMIT;

   logic [31:0] strobe_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    strobe_run <= '0;
      else if (!bus_oe_n || !bus_we_n) strobe_run <= strobe_run + 32'd1;
      else                           strobe_run <= '0;
   end

   // R4: only one strobe at a time
   a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_oe_n && !bus_we_n));

   // R4: strobes only inside chip-enable
   a_r4_strobe_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_oe_n || !bus_we_n) |-> !bus_ce_n);

   // R6: done lasts one cycle and the block is idle then
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (req_ready && bus_ce_n));

   // R2: address stable during an access
   a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && $past(!req_ready)) |-> $stable(bus_addr));

   // R12: data drive only under chip-enable
   a_r12_drive_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
      bus_data_oe |-> !bus_ce_n);

   // R13: chip-enable never asserted while idle
   a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (bus_ce_n && bus_oe_n && bus_we_n));

   // R10: strobe run is bounded by the wait limit
   a_r10_strobe_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_run <= 32'(STROBE_MAX));

   // R10: error flag only changes at acceptance or strobe end
   a_r10_err_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wait_err) |-> bus_oe_n && bus_we_n && !bus_ce_n);

endmodule

bind csbus_strobe_gen csbus_strobe_gen_chk #(
   .ADDR_W     (ADDR_W),
   .FIELD_W    (FIELD_W),
   .WAIT_LIMIT (WAIT_LIMIT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ready   (req_ready),
   .done        (done),
   .bus_ce_n    (bus_ce_n),
   .bus_oe_n    (bus_oe_n),
   .bus_we_n    (bus_we_n),
   .bus_data_oe (bus_data_oe),
   .wait_err    (wait_err),
   .bus_addr    (bus_addr)
);

// File: tb/test_csbus_strobe_gen.sv
`timescale 1ns/1ps
module test_csbus_strobe_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [15:0] req_addr = '0, req_wdata = '0;
   logic        req_ready;
   logic [1:0]  cfg_mult = 2'd1;
   logic [5:0]  cfg_adr = '0, cfg_ce = '0, cfg_oe = '0, cfg_we = '0;
   logic [5:0]  cfg_rd_hld = '0, cfg_wr_hld = '0, cfg_pause = '0;
   logic        cfg_wait_en = 1'b0, dev_iordy = 1'b1;
   logic [15:0] bus_addr, bus_wdata, bus_rdata = '0, rdata;
   logic        bus_data_oe, bus_ce_n, bus_oe_n, bus_we_n, done, wait_err;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;
   logic [15:0] prev_rdata = '0;

   always #2.5 clk = ~clk;

   csbus_strobe_gen i_csbus_strobe_gen (.*);

   task automatic chk(input bit ok, input string rq, input int actual, input int expected);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", rq, actual, expected);
      end
   endtask

   function automatic int mval(input logic [1:0] code);
      case (code)
         2'd1: return 1;
         2'd2: return 2;
         2'd0: return 4;
         default: return 8;
      endcase
   endfunction

   // rel: -2 ready high throughout, -1 ready low throughout, k>0 released in k-th strobe cycle
   task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                         input logic [1:0] m, input int fa, input int fc, input int fo,
                         input int fw, input int fr, input int fh, input int fp,
                         input bit wen, input int rel);
      int mul, e_adr, e_ce, e_act, e_hld, e_pau, n;
      int c_adr, c_ce, c_act, c_hld, c_pau, cyc;
      int addr_bad, oe_bad, wrong_strobe;
      bit inject, e_err;
      logic [15:0] last_rd;
      mul   = mval(m);
      e_adr = (fa + 1) * mul;
      e_ce  = (fc + 1) * mul;
      n     = ((wr ? fw : fo) + 1) * mul;
      e_hld = ((wr ? fh : fr) + 1) * mul;
      e_pau = (fp + 1) * mul;
      e_err = wen && (rel == -1);
      if (!wen || rel == -2) e_act = n;
      else if (rel == -1)    e_act = n + 255;
      else                   e_act = (n > rel + 2) ? n : rel + 2;

      @(negedge clk);
      dev_iordy = (rel == -2);
      repeat (3) @(negedge clk);
      cfg_mult = m; cfg_adr = 6'(fa); cfg_ce = 6'(fc); cfg_oe = 6'(fo); cfg_we = 6'(fw);
      cfg_rd_hld = 6'(fr); cfg_wr_hld = 6'(fh); cfg_pause = 6'(fp); cfg_wait_en = wen;
      req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_write = ~wr;
      c_adr = 0; c_ce = 0; c_act = 0; c_hld = 0; c_pau = 0;
      addr_bad = 0; oe_bad = 0; wrong_strobe = 0; inject = 0; last_rd = '0;
      for (cyc = 0; cyc < 3000; cyc++) begin
         if (inject) begin req_valid = 1'b0; inject = 0; end
         if (done) break;
         if (bus_addr !== a) addr_bad++;
         if (wr ? (bus_data_oe !== !bus_ce_n || (bus_data_oe && bus_wdata !== d)) : bus_data_oe !== 1'b0)
            oe_bad++;
         if (wr ? bus_oe_n !== 1'b1 : bus_we_n !== 1'b1) wrong_strobe++;
         if (!bus_oe_n || !bus_we_n) begin
            c_act++;
            if (c_act == 1) begin req_valid = 1'b1; inject = 1; end
            if (rel > 0 && c_act == rel) dev_iordy = 1'b1;
         end else if (!bus_ce_n) begin
            if (c_act == 0) c_ce++; else c_hld++;
         end else if (!req_ready) begin
            if (c_act == 0) c_adr++; else c_pau++;
         end
         bus_rdata = 16'($urandom);
         if (!bus_oe_n) last_rd = bus_rdata;
         @(negedge clk);
      end
      chk(done === 1'b1, "R6 done reached", cyc, e_adr + e_ce + e_act + e_hld + e_pau);
      chk(c_adr == e_adr, "R2/R7 address phase", c_adr, e_adr);
      chk(addr_bad == 0, "R2 address held", addr_bad, 0);
      chk(c_ce == e_ce, "R3 enable setup", c_ce, e_ce);
      chk(c_act == e_act, (wen ? "R8/R10 strobe width" : (rel == -2 ? "R4 strobe width" : "R9 strobe width")), c_act, e_act);
      chk(wrong_strobe == 0, "R4 other strobe high", wrong_strobe, 0);
      chk(c_hld == e_hld, "R5 hold", c_hld, e_hld);
      chk(c_pau == e_pau, "R6 pause", c_pau, e_pau);
      chk(oe_bad == 0, "R12 data drive", oe_bad, 0);
      chk(wait_err === e_err, "R10 wait error", int'(wait_err), int'(e_err));
      if (!wr) prev_rdata = last_rd;
      chk(rdata === prev_rdata, "R11 read capture", int'(rdata), int'(prev_rdata));
      @(negedge clk);
      chk(done === 1'b0, "R6 done one cycle", int'(done), 0);
      for (int i = 0; i < 2; i++) begin
         chk(req_ready === 1'b1 && bus_ce_n === 1'b1, "R13 injected request dropped",
             int'(bus_ce_n), 1);
         @(negedge clk);
      end
      dev_iordy = 1'b1;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_ce_n === 1'b1 && bus_oe_n === 1'b1 && bus_we_n === 1'b1, "R1 strobes idle",
          int'({bus_ce_n, bus_oe_n, bus_we_n}), 7);
      chk(req_ready === 1'b1 && done === 1'b0 && wait_err === 1'b0, "R1 status idle",
          int'({req_ready, done, wait_err}), 4);

      // R7: each multiplier code, read
      access(0, 16'h1000, 16'h0, 2'd1, 1, 2, 3, 0, 1, 0, 2, 0, -2);
      access(0, 16'h1002, 16'h0, 2'd2, 1, 2, 3, 0, 1, 0, 2, 0, -2);
      access(0, 16'h1004, 16'h0, 2'd0, 1, 2, 3, 0, 1, 0, 2, 0, -2);
      access(0, 16'h1006, 16'h0, 2'd3, 1, 2, 3, 0, 1, 0, 2, 0, -2);
      // all zero fields: one cycle per phase
      access(0, 16'h0001, 16'h0, 2'd1, 0, 0, 0, 0, 0, 0, 0, 0, -2);
      // write, R4 R5 R12
      access(1, 16'h2000, 16'hBEEF, 2'd1, 2, 1, 0, 4, 0, 3, 1, 0, -2);
      access(1, 16'h2002, 16'h1234, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0, -2);
      // R8: stretch released late and early
      access(0, 16'h3000, 16'h0, 2'd1, 0, 0, 1, 0, 0, 0, 0, 1, 9);
      access(1, 16'h3002, 16'h5A5A, 2'd1, 0, 1, 0, 1, 0, 0, 0, 1, 20);
      access(0, 16'h3004, 16'h0, 2'd2, 0, 0, 5, 0, 0, 0, 0, 1, 1);
      // R9: ready low but wait disabled
      access(0, 16'h4000, 16'h0, 2'd1, 0, 0, 3, 0, 0, 0, 0, 0, -1);
      // R10: timeout then clear
      access(0, 16'h5000, 16'h0, 2'd1, 0, 0, 2, 0, 0, 0, 0, 1, -1);
      access(1, 16'h5002, 16'h7777, 2'd1, 0, 0, 0, 0, 0, 0, 0, 1, -1);
      access(0, 16'h5004, 16'h0, 2'd1, 0, 0, 0, 0, 0, 0, 0, 0, -2);

      for (int t = 0; t < 40; t++) begin
         bit wen_r;
         int rel_r;
         wen_r = ($urandom % 2) == 1;
         case ($urandom % 3)
            0: rel_r = -2;
            1: rel_r = wen_r ? 1 + int'($urandom % 30) : -1;
            default: rel_r = 1 + int'($urandom % 30);
         endcase
         access(($urandom % 2) == 1, 16'($urandom), 16'($urandom), 2'($urandom),
                int'($urandom % 8), int'($urandom % 8), int'($urandom % 8), int'($urandom % 8),
                int'($urandom % 8), int'($urandom % 8), int'($urandom % 8), wen_r, rel_r);
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule